// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block collects every interrupt source of a multi-stream audio controller and folds them into one 32-bit interrupt status word and one level-sensitive interrupt request line. The sources are the response-ring events (response received and ring overrun), codec state-change events with a per-codec wake-enable mask, and three event kinds per stream descriptor: completion, FIFO error and descriptor error. Hardware event pulses latch into sticky status bits. A status bit only counts towards the status word when its matching enable bit in the source's control register is also set.

Software owns the control registers and clears status through a simple write port that uses write-one-to-clear semantics. The status word places the input streams in its lowest bits, the output streams directly above them, the controller summary at bit 30 and the global summary at bit 31. The request line is gated by a global enable and by per-source enables in the interrupt control word. The global summary bit is never part of that gating, so the global summary can read as set while the line stays low.

Top module: `aud_irq_agg`

## Requirements
- R1: After reset every status, enable and control register is zero, `int_sts_o` reads 0 and `irq_o` is low.
- R2: Bit 30 of `int_sts_o` is set while (ring status AND ring control) is nonzero. The ring control register is at address 1 and the ring status register is at address 2. In both, bit 0 is response-received and bit 1 is overrun. In `ring_evt_i`, bit 0 is response-received and bit 1 is overrun.
- R3: Bit 30 of `int_sts_o` is also set while (codec state-change status AND wake-enable) is nonzero. The wake-enable register is at address 3. The codec status register is at address 4, with bit c belonging to codec c and set by `codec_evt_i[c]`.
- R4: Bit n of `int_sts_o` is set while (stream n status AND stream n control) is nonzero. Each stream has a 3-bit field where bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error. Stream n's register is at address 16+n: data[2:0] write the control enables and data[10:8] clear status bits.
- R5: The input streams take stream indices 0..N_IN-1 and the output streams take N_IN..N_IN+N_OUT-1. Input stream k is fed by `in_evt_i[3k+2:3k]` and output stream k is fed by `out_evt_i[3k+2:3k]`. Status bits between the last stream and bit 30 read 0.
- R6: Bit 31 of `int_sts_o` is set exactly when any of bits 30..0 is set.
- R7: `irq_o` is high only when the global enable is set and (status word AND enable word) is nonzero. The interrupt control word is at address 0: bit 31 is the global enable, bit 30 enables the controller bit, and bits N_IN+N_OUT-1..0 enable the streams.
- R8: Status bits, including bit 31, can be set while `irq_o` is low, when the global enable or the matching source enable is clear.
- R9: Writing a one to a status bit clears it and writing a zero leaves it unchanged. An event for the same bit in the same cycle wins over the clear.
- R10: An event latches its status bit whether or not its control enable is set, so enabling the source later exposes the pending event.
- R11: `int_sts_o` and `irq_o` reflect a write or an event right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| ring_evt_i | input | 2 | Response-ring event pulses (bit 0 response, bit 1 overrun) |
| codec_evt_i | input | CODEC_W | Codec state-change event pulses |
| in_evt_i | input | 3*N_IN | Input stream event pulses, 3 bits per stream |
| out_evt_i | input | 3*N_OUT | Output stream event pulses, 3 bits per stream |
| int_sts_o | output | 32 | Interrupt status word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded properties check several rules on every cycle. An event always latches its status bit. A one written with no competing event always clears the bit. The line never rises without the global summary bit. It is always low in the cycle after the global enable is written as zero. Only the bench's scenarios can show the mapping of output streams above input streams and the event-over-clear priority. They also show pending events appearing when an enable is written later, and the global summary bit standing high with the line low. The bench checks these against a model of the registers, using a mix of random writes and events.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned RING_W    = 2;
  localparam int unsigned STRM_EV_W = 3;
  localparam int unsigned BIT_CTRL  = 30;
  localparam int unsigned BIT_GLOB  = 31;
  localparam int unsigned W1C_LSB   = 8;

  localparam logic [ADDR_W-1:0] A_INTCTL   = 6'd0;
  localparam logic [ADDR_W-1:0] A_RINGCTL  = 6'd1;
  localparam logic [ADDR_W-1:0] A_RINGSTS  = 6'd2;
  localparam logic [ADDR_W-1:0] A_WAKE     = 6'd3;
  localparam logic [ADDR_W-1:0] A_CODECSTS = 6'd4;
  localparam int unsigned       A_STRM_BASE = 16;
endpackage

// File: rtl/aud_irq_src_regs.sv
module aud_irq_src_regs
  import aud_irq_pkg::*;
#(
  parameter int unsigned CODEC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic [RING_W-1:0]  ring_evt_i,
  input  logic [CODEC_W-1:0] codec_evt_i,
  output logic               ctrl_hit_o
);
  logic [RING_W-1:0]  ring_ctl_q, ring_sts_q, ring_clr;
  logic [CODEC_W-1:0] wake_q, codec_sts_q, codec_clr;
  logic               unused_data;

  assign unused_data = ^wr_data_i;
  assign ring_clr  = (wr_en_i && wr_addr_i == A_RINGSTS)  ? wr_data_i[RING_W-1:0]  : '0;
  assign codec_clr = (wr_en_i && wr_addr_i == A_CODECSTS) ? wr_data_i[CODEC_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_ctl_q  <= '0;
      ring_sts_q  <= '0;
      wake_q      <= '0;
      codec_sts_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_RINGCTL) ring_ctl_q <= wr_data_i[RING_W-1:0];
      if (wr_en_i && wr_addr_i == A_WAKE)    wake_q     <= wr_data_i[CODEC_W-1:0];
      // event beats a same-cycle clear
      ring_sts_q  <= (ring_sts_q  & ~ring_clr)  | ring_evt_i;
      codec_sts_q <= (codec_sts_q & ~codec_clr) | codec_evt_i;
    end
  end

  assign ctrl_hit_o = (|(ring_sts_q & ring_ctl_q)) | (|(codec_sts_q & wake_q));

  AST_RING_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ring_evt_i) |=> ((ring_sts_q & $past(ring_evt_i)) == $past(ring_evt_i))); // R10
  AST_CODEC_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|codec_evt_i) |=> ((codec_sts_q & $past(codec_evt_i)) == $past(codec_evt_i))); // R10
  AST_RING_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_RINGSTS && ring_evt_i == '0)
      |=> ((ring_sts_q & $past(wr_data_i[RING_W-1:0])) == '0)); // R9
  AST_CODEC_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CODECSTS && codec_evt_i == '0)
      |=> ((codec_sts_q & $past(wr_data_i[CODEC_W-1:0])) == '0)); // R9
endmodule

// File: rtl/aud_irq_strm_unit.sv
module aud_irq_strm_unit
  import aud_irq_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [31:0]          wr_data_i,
  input  logic [STRM_EV_W-1:0] evt_i,
  output logic                 hit_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_STRM_BASE + IDX);

  logic [STRM_EV_W-1:0] ctl_q, sts_q, clr;
  logic                 sel;
  logic                 unused_data;

  assign unused_data = ^wr_data_i;
  assign sel = wr_en_i && (wr_addr_i == MY_ADDR);
  assign clr = sel ? wr_data_i[W1C_LSB +: STRM_EV_W] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      sts_q <= '0;
    end else begin
      if (sel) ctl_q <= wr_data_i[STRM_EV_W-1:0];
      sts_q <= (sts_q & ~clr) | evt_i;
    end
  end

  assign hit_o = |(sts_q & ctl_q);

  AST_STRM_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i))); // R10
  AST_STRM_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && evt_i == '0) |=> ((sts_q & $past(wr_data_i[W1C_LSB +: STRM_EV_W])) == '0)); // R9
endmodule

// File: rtl/aud_irq_merge.sv
module aud_irq_merge
  import aud_irq_pkg::*;
#(
  parameter int unsigned NSTRM = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              ctrl_hit_i,
  input  logic [NSTRM-1:0]  strm_hit_i,
  output logic [31:0]       int_sts_o,
  output logic              irq_o
);
  logic             gie_q, cie_q;
  logic [NSTRM-1:0] sie_q;
  logic [31:0]      sts_w, en_w;
  logic             unused_data;

  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      cie_q <= 1'b0;
      sie_q <= '0;
    end else if (wr_en_i && wr_addr_i == A_INTCTL) begin
      gie_q <= wr_data_i[BIT_GLOB];
      cie_q <= wr_data_i[BIT_CTRL];
      sie_q <= wr_data_i[NSTRM-1:0];
    end
  end

  always_comb begin
    sts_w = '0;
    sts_w[NSTRM-1:0] = strm_hit_i;
    sts_w[BIT_CTRL]  = ctrl_hit_i;
    sts_w[BIT_GLOB]  = |sts_w[BIT_GLOB-1:0];
    en_w = '0;
    en_w[NSTRM-1:0] = sie_q;
    en_w[BIT_CTRL]  = cie_q;
  end

  // global status bit is not part of the gating
  assign irq_o     = gie_q && (|(sts_w & en_w));
  assign int_sts_o = sts_w;
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
  import aud_irq_pkg::*;
#(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_OUT   = 4,
  parameter int unsigned CODEC_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [31:0]                wr_data_i,
  input  logic [RING_W-1:0]          ring_evt_i,
  input  logic [CODEC_W-1:0]         codec_evt_i,
  input  logic [N_IN*STRM_EV_W-1:0]  in_evt_i,
  input  logic [N_OUT*STRM_EV_W-1:0] out_evt_i,
  output logic [31:0]                int_sts_o,
  output logic                       irq_o
);
  localparam int unsigned NSTRM = N_IN + N_OUT;

  logic             ctrl_hit;
  logic [NSTRM-1:0] strm_hit;

  aud_irq_src_regs #(.CODEC_W(CODEC_W)) u_src (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ring_evt_i, .codec_evt_i, .ctrl_hit_o(ctrl_hit)
  );

  for (genvar s = 0; s < NSTRM; s++) begin : g_strm
    logic [STRM_EV_W-1:0] evt;
    if (s < N_IN) begin : g_in
      assign evt = in_evt_i[s*STRM_EV_W +: STRM_EV_W];
    end else begin : g_out
      assign evt = out_evt_i[(s-N_IN)*STRM_EV_W +: STRM_EV_W];
    end
    aud_irq_strm_unit #(.IDX(s)) u_strm (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
      .evt_i(evt), .hit_o(strm_hit[s])
    );
  end

  aud_irq_merge #(.NSTRM(NSTRM)) u_merge (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_hit_i(ctrl_hit), .strm_hit_i(strm_hit),
    .int_sts_o, .irq_o
  );

  AST_IRQ_NEEDS_GLOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_sts_o[BIT_GLOB]); // R8
  AST_IRQ_GIE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_INTCTL && !wr_data_i[BIT_GLOB]) |=> !irq_o); // R7
  AST_IRQ_NO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_sts_o[BIT_GLOB-1:0] == '0) |-> !irq_o); // R7
endmodule

// File: tb/aud_irq_agg_tb.sv
`timescale 1ns/1ps
module aud_irq_agg_tb;
  localparam int NI = 4, NO = 4, CW = 4, NS = NI + NO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] ring_evt = '0;
  logic [CW-1:0] codec_evt = '0;
  logic [NI*3-1:0] in_evt = '0;
  logic [NO*3-1:0] out_evt = '0;
  logic [31:0] int_sts;
  logic irq;

  int checks = 0, errors = 0;

  // bench model
  logic [1:0] m_rctl, m_rsts;
  logic [CW-1:0] m_wake, m_csts;
  logic [2:0] m_sctl [NS];
  logic [2:0] m_ssts [NS];
  logic m_gie, m_cie;
  logic [NS-1:0] m_sie;

  always #5 clk = ~clk;

  aud_irq_agg #(.N_IN(NI), .N_OUT(NO), .CODEC_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ring_evt_i(ring_evt), .codec_evt_i(codec_evt),
    .in_evt_i(in_evt), .out_evt_i(out_evt), .int_sts_o(int_sts), .irq_o(irq)
  );

  function automatic logic [31:0] exp_sts();
    logic [31:0] s = '0;
    for (int n = 0; n < NS; n++) s[n] = |(m_ssts[n] & m_sctl[n]);
    s[30] = (|(m_rsts & m_rctl)) || (|(m_csts & m_wake));
    s[31] = |s[30:0];
    return s;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] s = exp_sts();
    return m_gie && ((s[30] && m_cie) || (|(s[NS-1:0] & m_sie)));
  endfunction

  task automatic model_reset();
    m_rctl = '0; m_rsts = '0; m_wake = '0; m_csts = '0;
    m_gie = 0; m_cie = 0; m_sie = '0;
    for (int n = 0; n < NS; n++) begin m_sctl[n] = '0; m_ssts[n] = '0; end
  endtask

  task automatic model_update();
    if (wr_en) begin
      case (wr_addr)
        6'd0: begin m_gie = wr_data[31]; m_cie = wr_data[30]; m_sie = wr_data[NS-1:0]; end
        6'd1: m_rctl = wr_data[1:0];
        6'd2: m_rsts = m_rsts & ~wr_data[1:0];
        6'd3: m_wake = wr_data[CW-1:0];
        6'd4: m_csts = m_csts & ~wr_data[CW-1:0];
        default:
          for (int n = 0; n < NS; n++)
            if (int'(wr_addr) == 16 + n) begin
              m_sctl[n] = wr_data[2:0];
              m_ssts[n] = m_ssts[n] & ~wr_data[10:8];
            end
      endcase
    end
    m_rsts = m_rsts | ring_evt;
    m_csts = m_csts | codec_evt;
    for (int n = 0; n < NI; n++) m_ssts[n] = m_ssts[n] | in_evt[n*3 +: 3];
    for (int n = 0; n < NO; n++) m_ssts[NI+n] = m_ssts[NI+n] | out_evt[n*3 +: 3];
  endtask

  // called at a negedge with inputs set; returns at the next negedge
  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    wr_en = 0; ring_evt = '0; codec_evt = '0; in_evt = '0; out_evt = '0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " sts"}, int_sts, exp_sts());
    chk({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sts", int_sts, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R10 pending ring event with control clear is invisible
    ring_evt = 2'b01; tick();
    chk("R10 masked", int_sts, 32'h0);
    // R2 enabling response control exposes it; R8 line low with GIE clear
    wr(6'd1, 32'h1);
    chk("R2 ring", int_sts, 32'hC000_0000);
    chk("R8 line low", {31'd0, irq}, 32'd0);
    // R7 enable global + controller
    wr(6'd0, 32'hC000_0000);
    chk("R7 irq on", {31'd0, irq}, 32'd1);
    // R9 write zero leaves bit
    wr(6'd2, 32'h0);
    chk("R9 w0", int_sts, 32'hC000_0000);
    // R9 R11 clear then line drops at once
    wr(6'd2, 32'h1);
    chk("R11 cleared", int_sts, 32'h0);
    chk("R11 irq off", {31'd0, irq}, 32'd0);
    // R2 overrun bit with overrun enable only
    wr(6'd1, 32'h2);
    ring_evt = 2'b01; tick();
    chk("R2 wrong bit", int_sts, 32'h0);
    ring_evt = 2'b10; tick();
    chk("R2 overrun", int_sts, 32'hC000_0000);
    wr(6'd2, 32'h3);

    // R3 codec path
    codec_evt = 4'b0100; tick();
    wr(6'd3, 32'h2);
    chk("R3 other wake", int_sts, 32'h0);
    wr(6'd3, 32'h4);
    chk("R3 codec", int_sts, 32'hC000_0000);
    wr(6'd4, 32'h4);
    chk_all("R3 clear");

    // R5 R4 output stream 0 sits at bit NI
    out_evt = 3'b100; tick();
    wr(6'(16 + NI), 32'h4);
    chk("R5 out0", int_sts, 32'h8000_0000 | (32'h1 << NI));
    chk("R8 no sie", {31'd0, irq}, 32'd0);
    wr(6'd0, 32'h8000_0000 | (32'h1 << NI));
    chk("R7 stream irq", {31'd0, irq}, 32'd1);
    // R4 input stream 1, completion
    in_evt = 6'b001_000; tick();
    wr(6'd17, 32'h1);
    chk("R4 in1", int_sts, 32'h8000_0002 | (32'h1 << NI));
    // R9 same-cycle event beats clear
    wr_en = 1; wr_addr = 6'd17; wr_data = 32'h0000_0101; in_evt = 6'b001_000; tick();
    chk("R9 evt wins", int_sts, 32'h8000_0002 | (32'h1 << NI));
    wr(6'd17, 32'h0000_0101);
    chk("R9 stream clr", int_sts, 32'h8000_0000 | (32'h1 << NI));
    // R7 GIE off drops line, R8 status stays
    wr(6'd0, 32'h0000_00FF);
    chk("R7 gie off", {31'd0, irq}, 32'd0);
    chk("R8 sts kept", int_sts, 32'h8000_0000 | (32'h1 << NI));
    chk_all("R6 dir");

    // random phase
    for (int i = 0; i < 500; i++) begin
      if ($urandom % 3 == 0) begin
        int sel = $urandom % (5 + NS);
        wr_en = 1;
        wr_addr = (sel < 5) ? 6'(sel) : 6'(16 + sel - 5);
        wr_data = $urandom;
      end
      if ($urandom % 6 == 0) ring_evt = 2'($urandom);
      if ($urandom % 6 == 0) codec_evt = CW'($urandom);
      if ($urandom % 4 == 0) in_evt = (NI*3)'($urandom) & (NI*3)'($urandom);
      if ($urandom % 4 == 0) out_evt = (NO*3)'($urandom) & (NO*3)'($urandom);
      tick();
      chk_all("R2 R3 R4 R6 R7 rand");
    end

    summary();
    $finish;
  end
endmodule